// File: doc/BRIEF.md
# Thermal Throttle Manager

This block decides when a core must slow down for heat, and how. It keeps the most recent digital temperature sample and compares it with a programmable throttle limit, a critical limit and two interrupt thresholds. Throttling starts when the sample reaches the throttle limit. It also starts when software sets an on-demand control bit, or when another agent on the board pulls the shared hot line. While the block is throttling for its own temperature, it drives that shared line.

On entry the block asks for a step-down to a lower operating point. If the step-down logic reports a failure, the block falls back to clock duty-cycle modulation. In that mode a 3-bit setting removes the clock enable for N of every 8 cycles. Interrupt strobes fire on threshold crossings, each with a sticky status bit, and on the selected edges of the hot line. A sample at or above the critical limit latches a trip output and stops the clock enable until reset.

Configuration arrives through a simple write port. The write port uses these addresses: 0 throttle limit, 1 hysteresis, 2 threshold 0, 3 threshold 1, 4 control, 5 status clear, 6 critical limit. The control register bits are: [2:0] duty setting N, bit 4 on-demand throttle, bit 5 interrupt on rising hot, bit 6 interrupt on falling hot.

Top module: `thermctl_top`

## Requirements
- R1: After reset, `throttle`, `hot_drv`, `trip`, `method_duty`, `thr_sts` and all interrupt strobes are 0 and `clk_en` is 1; defaults are limit 100, hysteresis 4, critical 125, thresholds 255, control 0.
- R2: When the held sample is greater than or equal to the throttle limit, `throttle` and `hot_drv` become 1.
- R3: Automatic throttling releases only when the sample is at or below limit minus hysteresis; a sample strictly between holds the current state.
- R4: Control bit 4 (address 4) set to 1 forces `throttle` to 1 at any temperature without driving `hot_drv`; clearing it lets throttling end when no other cause remains.
- R5: A high `hot_in` forces `throttle` to 1 while `hot_drv` stays 0.
- R6: Each throttle episode starts with `method_duty`=0; a `step_done` strobe with `step_ok`=0 during throttling switches it to 1; a strobe with `step_ok`=1 leaves it 0; it returns to 0 when throttling ends.
- R7: While throttling with `method_duty`=1, `clk_en` is 0 in exactly N of every 8 consecutive cycles, where N is control bits [2:0]; N=0 never gates.
- R8: For each threshold i (address 2 for i=0, address 3 for i=1), a sample change that moves it from below to at-or-above the threshold, or back, gives one `irq_thr[i]` pulse and sets `thr_sts[i]`.
- R9: A write to address 5 clears `thr_sts[i]` for each data bit i that is 1 and leaves the other status bits as they were.
- R10: `irq_hot` pulses once on each rising edge of the combined hot level (`hot_drv` OR `hot_in`) when control bit 5 is 1, and on each falling edge when control bit 6 is 1; disabled edges give no pulse.
- R11: A sample greater than or equal to the critical limit sets `trip` and forces `clk_en` to 0; both hold until reset, even after the temperature falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_vld | input | 1 | New temperature sample present |
| temp | input | TW | Temperature sample |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | TW | Register write data |
| step_done | input | 1 | Step-down attempt finished (strobe) |
| step_ok | input | 1 | Step-down attempt succeeded, valid with step_done |
| hot_in | input | 1 | Hot line as asserted by other agents |
| throttle | output | 1 | Throttling active |
| method_duty | output | 1 | 0 step-down, 1 duty-cycle modulation |
| clk_en | output | 1 | Core clock enable |
| hot_drv | output | 1 | Drive the shared hot line |
| irq_hot | output | 1 | Hot edge interrupt strobe |
| irq_thr | output | 2 | Threshold crossing strobes |
| thr_sts | output | 2 | Sticky threshold crossing status |
| trip | output | 1 | Catastrophic trip |

## Verification
The hardest state to reach is duty-cycle modulation. To get there the block must already be throttling, and a failed step-down report must arrive inside that episode. The stimulus therefore forces throttling with the on-demand bit at a cool temperature and then sends a successful step-down strobe followed by a failed one. It then counts gated cycles over an 8-cycle window for several duty settings. Threshold and hysteresis behaviour comes from a fixed-seed random walk of temperatures. The bench follows that walk with its own model of hot state, crossing direction and sticky status, and clears the status at chosen points.

// File: rtl/thermctl_pkg.sv
package thermctl_pkg;

    typedef enum logic {
        THR_STEP = 1'b0,
        THR_DUTY = 1'b1
    } thr_method_e;

    localparam int NTHR   = 2;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_LIMIT = 3'd0;
    localparam logic [ADDR_W-1:0] A_HYST  = 3'd1;
    localparam logic [ADDR_W-1:0] A_THR0  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd4;
    localparam logic [ADDR_W-1:0] A_CLR   = 3'd5;
    localparam logic [ADDR_W-1:0] A_CRIT  = 3'd6;

    localparam int DUTY_W     = 3;
    localparam int C_ONDEMAND = 4;
    localparam int C_IRQ_RISE = 5;
    localparam int C_IRQ_FALL = 6;

endpackage

// File: rtl/thermctl_regs.sv
module thermctl_regs
    import thermctl_pkg::*;
#(
    parameter int TW = 8,
    parameter logic [TW-1:0] LIMIT_RST = 8'd100,
    parameter logic [TW-1:0] HYST_RST  = 8'd4,
    parameter logic [TW-1:0] CRIT_RST  = 8'd125
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [TW-1:0]             wdata,
    output logic [TW-1:0]             limit,
    output logic [TW-1:0]             hyst,
    output logic [TW-1:0]             crit,
    output logic [NTHR-1:0][TW-1:0]   thr,
    output logic [DUTY_W-1:0]         duty_n,
    output logic                      ondemand,
    output logic                      irq_rise_en,
    output logic                      irq_fall_en,
    output logic [NTHR-1:0]           clr
);

    typedef struct packed {
        logic [TW-1:0]           limit;
        logic [TW-1:0]           hyst;
        logic [TW-1:0]           crit;
        logic [NTHR-1:0][TW-1:0] thr;
        logic [DUTY_W-1:0]       duty_n;
        logic                    ondemand;
        logic                    rise_en;
        logic                    fall_en;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            unique case (addr)
                A_LIMIT: r_d.limit = wdata;
                A_HYST:  r_d.hyst  = wdata;
                A_CRIT:  r_d.crit  = wdata;
                A_CTRL: begin
                    r_d.duty_n   = wdata[DUTY_W-1:0];
                    r_d.ondemand = wdata[C_ONDEMAND];
                    r_d.rise_en  = wdata[C_IRQ_RISE];
                    r_d.fall_en  = wdata[C_IRQ_FALL];
                end
                default: ;
            endcase
            for (int i = 0; i < NTHR; i++) begin
                if (addr == ADDR_W'(int'(A_THR0) + i)) begin
                    r_d.thr[i] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.limit    <= LIMIT_RST;
            r_q.hyst     <= HYST_RST;
            r_q.crit     <= CRIT_RST;
            r_q.thr      <= '1;
            r_q.duty_n   <= '0;
            r_q.ondemand <= 1'b0;
            r_q.rise_en  <= 1'b0;
            r_q.fall_en  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign limit       = r_q.limit;
    assign hyst        = r_q.hyst;
    assign crit        = r_q.crit;
    assign thr         = r_q.thr;
    assign duty_n      = r_q.duty_n;
    assign ondemand    = r_q.ondemand;
    assign irq_rise_en = r_q.rise_en;
    assign irq_fall_en = r_q.fall_en;
    assign clr         = (we && addr == A_CLR) ? wdata[NTHR-1:0] : '0;

endmodule

// File: rtl/thermctl_xing.sv
module thermctl_xing #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] level,
    input  logic          clr,
    output logic          irq,
    output logic          sts
);

    typedef struct packed {
        logic above;
        logic irq;
        logic sts;
    } xing_t;

    xing_t x_d, x_q;

    always_comb begin
        x_d       = x_q;
        x_d.above = (temp >= level);
        x_d.irq   = (x_d.above != x_q.above);
        if (clr) begin
            x_d.sts = 1'b0;
        end
        if (x_d.irq) begin
            x_d.sts = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0;
        end else begin
            x_q <= x_d;
        end
    end

    assign irq = x_q.irq;
    assign sts = x_q.sts;

    p_irq_sets_sts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        x_q.irq |-> x_q.sts);

    p_irq_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        x_q.irq |-> (x_q.above != $past(x_q.above)));

endmodule

// File: rtl/thermctl_duty.sv
module thermctl_duty #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [CW-1:0] n,
    output logic          en
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = active ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign en = !(active && (cnt_q < n));

    p_cnt_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(active) |-> (cnt_q == CW'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/thermctl_top.sv
module thermctl_top
    import thermctl_pkg::*;
#(
    parameter int TW = 8,
    parameter logic [TW-1:0] LIMIT_RST = 8'd100,
    parameter logic [TW-1:0] HYST_RST  = 8'd4,
    parameter logic [TW-1:0] CRIT_RST  = 8'd125
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                temp_vld,
    input  logic [TW-1:0]       temp,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [TW-1:0]       reg_wdata,
    input  logic                step_done,
    input  logic                step_ok,
    input  logic                hot_in,
    output logic                throttle,
    output logic                method_duty,
    output logic                clk_en,
    output logic                hot_drv,
    output logic                irq_hot,
    output logic [NTHR-1:0]     irq_thr,
    output logic [NTHR-1:0]     thr_sts,
    output logic                trip
);

    logic [TW-1:0]           limit, hyst, crit;
    logic [NTHR-1:0][TW-1:0] thr;
    logic [DUTY_W-1:0]       duty_n;
    logic                    ondemand, rise_en, fall_en;
    logic [NTHR-1:0]         clr;
    logic                    duty_en;
    logic                    hot_eff;
    logic                    release_ok;

    typedef struct packed {
        logic [TW-1:0] temp;
        logic          hot_auto;
        logic          throttle;
        thr_method_e   method;
        logic          trip;
        logic          hot_in;
        logic          hot_prev;
        logic          irq_hot;
    } top_t;

    top_t s_d, s_q;

    thermctl_regs #(
        .TW(TW), .LIMIT_RST(LIMIT_RST), .HYST_RST(HYST_RST), .CRIT_RST(CRIT_RST)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .limit(limit), .hyst(hyst), .crit(crit), .thr(thr), .duty_n(duty_n),
        .ondemand(ondemand), .irq_rise_en(rise_en), .irq_fall_en(fall_en), .clr(clr)
    );

    for (genvar g = 0; g < NTHR; g++) begin : g_xing
        thermctl_xing #(.TW(TW)) xing_i (
            .clk(clk), .rst_n(rst_n), .temp(s_q.temp), .level(thr[g]),
            .clr(clr[g]), .irq(irq_thr[g]), .sts(thr_sts[g])
        );
    end

    thermctl_duty #(.CW(DUTY_W)) duty_i (
        .clk(clk), .rst_n(rst_n),
        .active(s_q.throttle && s_q.method == THR_DUTY),
        .n(duty_n), .en(duty_en)
    );

    assign release_ok = ({1'b0, s_q.temp} + {1'b0, hyst}) <= {1'b0, limit};
    assign hot_eff    = s_q.hot_auto | s_q.hot_in;

    always_comb begin
        s_d = s_q;
        if (temp_vld) begin
            s_d.temp = temp;
        end
        if (s_q.temp >= limit) begin
            s_d.hot_auto = 1'b1;
        end else if (release_ok) begin
            s_d.hot_auto = 1'b0;
        end
        s_d.hot_in   = hot_in;
        s_d.throttle = s_q.hot_auto | ondemand | s_q.hot_in;
        if (!s_q.throttle) begin
            s_d.method = THR_STEP;
        end else if (step_done && !step_ok) begin
            s_d.method = THR_DUTY;
        end
        s_d.trip     = s_q.trip | (s_q.temp >= crit);
        s_d.hot_prev = hot_eff;
        s_d.irq_hot  = (hot_eff && !s_q.hot_prev && rise_en) ||
                       (!hot_eff && s_q.hot_prev && fall_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.temp     <= '0;
            s_q.hot_auto <= 1'b0;
            s_q.throttle <= 1'b0;
            s_q.method   <= THR_STEP;
            s_q.trip     <= 1'b0;
            s_q.hot_in   <= 1'b0;
            s_q.hot_prev <= 1'b0;
            s_q.irq_hot  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign throttle    = s_q.throttle;
    assign method_duty = (s_q.method == THR_DUTY);
    assign clk_en      = duty_en && !s_q.trip;
    assign hot_drv     = s_q.hot_auto;
    assign irq_hot     = s_q.irq_hot;
    assign trip        = s_q.trip;

    p_ondemand_forces_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ondemand |=> s_q.throttle);

    p_trip_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.trip |=> (s_q.trip && !clk_en));

    p_duty_after_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.method == THR_DUTY) |-> $past(step_done && !step_ok && s_q.throttle));

    p_hot_irq_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq_hot |-> (s_q.hot_prev != $past(s_q.hot_prev)));

    p_release_hyst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.hot_auto) |-> $past(release_ok));

endmodule

// File: tb/thermctl_top_tb_top.sv
module thermctl_top_tb_top;

    localparam int TW = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         temp_vld = 1'b0;
    logic [7:0]   temp = '0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [7:0]   reg_wdata = '0;
    logic         step_done = 1'b0;
    logic         step_ok = 1'b0;
    logic         hot_in = 1'b0;
    logic         throttle, method_duty, clk_en, hot_drv, irq_hot, trip;
    logic [1:0]   irq_thr, thr_sts;

    int checks = 0;
    int failures = 0;
    int cnt_hot = 0;
    int cnt_thr0 = 0;
    int cnt_thr1 = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    thermctl_top #(.TW(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .temp_vld(temp_vld), .temp(temp),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .step_done(step_done), .step_ok(step_ok), .hot_in(hot_in),
        .throttle(throttle), .method_duty(method_duty), .clk_en(clk_en),
        .hot_drv(hot_drv), .irq_hot(irq_hot), .irq_thr(irq_thr),
        .thr_sts(thr_sts), .trip(trip)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_hot)    cnt_hot  <= cnt_hot + 1;
            if (irq_thr[0]) cnt_thr0 <= cnt_thr0 + 1;
            if (irq_thr[1]) cnt_thr1 <= cnt_thr1 + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_temp(input logic [7:0] t);
        @(negedge clk);
        temp_vld = 1'b1; temp = t;
        @(negedge clk);
        temp_vld = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic step_report(input bit ok);
        @(negedge clk);
        step_done = 1'b1; step_ok = ok;
        @(negedge clk);
        step_done = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_hot_in(input bit v);
        @(negedge clk);
        hot_in = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic count_gated(output int lows);
        lows = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!clk_en) lows++;
        end
    endtask

    function automatic bit model_hot(input bit prev, input int t, input int lim, input int hy);
        if (t >= lim) return 1'b1;
        if (t + hy <= lim) return 1'b0;
        return prev;
    endfunction

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
        end
    end

    initial begin
        int lows, h0, t0, t1, exp_t0, exp_t1;
        bit mhot;
        bit [1:0] msts, mabv;
        void'($urandom(32'd20240607));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk_eq("R1 throttle", throttle, 0);
        chk_eq("R1 hot_drv", hot_drv, 0);
        chk_eq("R1 trip", trip, 0);
        chk_eq("R1 clk_en", clk_en, 1);
        chk_eq("R1 method", method_duty, 0);
        chk_eq("R1 sts", thr_sts, 0);

        // R2 boundary: exactly at limit
        set_temp(8'd100);
        chk_eq("R2 throttle at limit", throttle, 1);
        chk_eq("R2 hot_drv at limit", hot_drv, 1);
        chk_eq("R10 no irq when disabled", cnt_hot, 0);

        // R3 hysteresis hold and release
        set_temp(8'd97);
        chk_eq("R3 hold inside band", throttle, 1);
        set_temp(8'd96);
        chk_eq("R3 release at limit-hyst", throttle, 0);
        chk_eq("R3 hot_drv released", hot_drv, 0);

        // R4 on-demand at cool temperature, duty setting 3
        set_temp(8'd50);
        wr(3'd4, 8'h13);
        chk_eq("R4 on-demand throttle", throttle, 1);
        chk_eq("R4 no hot_drv", hot_drv, 0);

        // R6 method selection
        chk_eq("R6 starts with step-down", method_duty, 0);
        step_report(1'b1);
        chk_eq("R6 success keeps step-down", method_duty, 0);
        step_report(1'b0);
        chk_eq("R6 failure selects duty", method_duty, 1);

        // R7 duty gating counts
        count_gated(lows);
        chk_eq("R7 N=3 gated cycles", lows, 3);
        wr(3'd4, 8'h17);
        count_gated(lows);
        chk_eq("R7 N=7 gated cycles", lows, 7);
        wr(3'd4, 8'h10);
        count_gated(lows);
        chk_eq("R7 N=0 gated cycles", lows, 0);

        wr(3'd4, 8'h00);
        repeat (3) @(negedge clk);
        chk_eq("R4 clearing ends throttle", throttle, 0);
        chk_eq("R6 method back to step", method_duty, 0);
        chk_eq("R7 clk_en idle", clk_en, 1);

        // R5 external hot
        set_hot_in(1'b1);
        chk_eq("R5 external hot throttles", throttle, 1);
        chk_eq("R5 no hot_drv", hot_drv, 0);
        set_hot_in(1'b0);
        chk_eq("R5 external release", throttle, 0);

        // R10 hot edge interrupts
        wr(3'd4, 8'h20);
        h0 = cnt_hot;
        set_hot_in(1'b1);
        set_hot_in(1'b0);
        chk_eq("R10 rise only", cnt_hot - h0, 1);
        wr(3'd4, 8'h60);
        h0 = cnt_hot;
        set_hot_in(1'b1);
        set_hot_in(1'b0);
        chk_eq("R10 both edges", cnt_hot - h0, 2);
        h0 = cnt_hot;
        set_temp(8'd105);
        set_temp(8'd50);
        chk_eq("R10 edges from own hot", cnt_hot - h0, 2);
        wr(3'd4, 8'h40);
        h0 = cnt_hot;
        set_hot_in(1'b1);
        chk_eq("R10 rise disabled", cnt_hot - h0, 0);
        set_hot_in(1'b0);
        chk_eq("R10 fall only", cnt_hot - h0, 1);
        wr(3'd4, 8'h00);

        // R8 / R9 directed
        wr(3'd2, 8'd60);
        wr(3'd3, 8'd90);
        t0 = cnt_thr0; t1 = cnt_thr1;
        set_temp(8'd95);
        chk_eq("R8 thr0 up pulse", cnt_thr0 - t0, 1);
        chk_eq("R8 thr1 up pulse", cnt_thr1 - t1, 1);
        chk_eq("R8 both sticky", thr_sts, 3);
        wr(3'd5, 8'h01);
        chk_eq("R9 clear bit0 only", thr_sts, 2);
        wr(3'd5, 8'h02);
        chk_eq("R9 clear bit1", thr_sts, 0);

        // random walk: R2 R3 R8 R9
        mhot = 1'b0;
        set_temp(8'd50);
        mabv = 2'b00; msts = 2'b11;
        wr(3'd5, 8'h03);
        msts = 2'b00;
        exp_t0 = cnt_thr0; exp_t1 = cnt_thr1;
        for (int it = 0; it < 40; it++) begin
            int t;
            bit [1:0] nabv;
            t = 40 + int'($urandom_range(80));
            set_temp(8'(t));
            mhot = model_hot(mhot, t, 100, 4);
            nabv = {bit'(t >= 90), bit'(t >= 60)};
            if (nabv[0] != mabv[0]) begin exp_t0++; msts[0] = 1'b1; end
            if (nabv[1] != mabv[1]) begin exp_t1++; msts[1] = 1'b1; end
            mabv = nabv;
            chk_eq("R3 random throttle", throttle, int'(mhot));
            chk_eq("R2 random hot_drv", hot_drv, int'(mhot));
            chk_eq("R8 random sts", thr_sts, int'(msts));
            if (it % 8 == 7) begin
                bit [1:0] c;
                c = 2'($urandom_range(3));
                wr(3'd5, {6'd0, c});
                msts = msts & ~c;
                chk_eq("R9 random clear", thr_sts, int'(msts));
            end
        end
        chk_eq("R8 random thr0 pulses", cnt_thr0, exp_t0);
        chk_eq("R8 random thr1 pulses", cnt_thr1, exp_t1);

        // R11 catastrophic trip
        set_temp(8'd125);
        chk_eq("R11 trip set", trip, 1);
        chk_eq("R11 clk_en stopped", clk_en, 0);
        set_temp(8'd40);
        chk_eq("R11 trip holds", trip, 1);
        count_gated(lows);
        chk_eq("R11 clock stays off", lows, 8);

        done = 1'b1;
        report();
    end

endmodule